// File: doc/BRIEF.md
# Time-over-threshold hit digitizer

The block turns the two discriminator outputs of each strip channel into time-stamped edge records. Every channel has a low-threshold comparator and a higher readout comparator. A scanner visits the eight channels one after another on the fast clock, so each channel is looked at once per coarse event-time period (eight fast cycles). Each comparator signal passes through a two-flop synchronizer. An edge is found by comparing a channel's sample in this period with its sample from the period before.

A rising readout comparator is accepted as a hit only while the same channel's low comparator is asserted. When it is accepted, a leading record is written. The falling edge that follows writes a trailing record. Each record carries the edge type, the channel number and the coarse period count. Downstream logic recovers the pulse height from the trailing time minus the leading time. Records go into a FIFO that the readout side pops continuously. There is no event buffering, so the only dead time a channel has is its own pulse width.

Two cases are handled without losing track of a channel. If a pulse stays open for too long, a trailing record with a saturated timestamp is forced. When the FIFO is full, new records are dropped and the drop is reported.

Top module: `tot_hit_digitizer`

## Requirements
- R1: After reset the FIFO is empty (`fifo_valid` = 0), `overflow` is 0 and `drop_count` is 0.
- R2: A rising readout comparator sampled while the channel's low comparator is high writes a leading record. In that record bit 19 is 1, bits 18:16 are the channel index, and bits 15:0 are the coarse period count at the visit. That count is the number of completed eight-cycle periods since reset, and it wraps at 16 bits.
- R3: A readout pulse whose rising sample sees the low comparator low writes no record, neither for its rise nor for its fall.
- R4: The falling edge of an accepted pulse writes a trailing record for the same channel with bit 19 = 0. For a pulse lasting W whole periods, its timestamp minus the leading timestamp equals W.
- R5: A trailing record is written only while the channel has an open leading record, and writing it closes that record.
- R6: If a channel is still open MAX_OPEN periods (default 255) after its leading record, a trailing record is forced for it with bits 15:0 = 0xFFFF. A later fall of that pulse writes nothing.
- R7: A record that arrives while the FIFO holds FIFO_DEPTH (default 16) entries is dropped. `overflow` is then set and stays set until reset, and `drop_count` increments, saturating at its maximum.
- R8: Records leave in the order they were written. The head word stays unchanged until it is popped with `rd_en` while `fifo_valid` is high.
- R9: All eight channels are served, each once per period. When all eight pulse together, one leading record and one trailing record appear for every channel index 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock, eight cycles per coarse period |
| rst_n | input | 1 | Synchronous active-low reset |
| low_cmp | input | 8 | Low-threshold comparator outputs, one per channel, asynchronous |
| rd_cmp | input | 8 | Readout-threshold comparator outputs, one per channel, asynchronous |
| rd_en | input | 1 | Pops the FIFO head when `fifo_valid` is high |
| fifo_valid | output | 1 | FIFO holds at least one record |
| fifo_word | output | 20 | Head record: {edge type, channel, timestamp} |
| overflow | output | 1 | Sticky flag: a record has been dropped |
| drop_count | output | 8 | Number of dropped records, saturating |

## Verification
A channel left open by mistake shows up within one period of the next readout fall as an extra trailing record, or as a missing leading record on the next pulse. A stuck age counter turns into a missing or early 0xFFFF record. A slot or period counter that is off by one changes the channel field, or the difference between the trailing and leading timestamps, in the very next pair of records. Wrong FIFO pointers show up as reordered or repeated head words as soon as the FIFO is drained. A wrong full count shows up as an early or late `overflow`, or as a `drop_count` that differs from the number of records offered beyond the depth.

// File: rtl/thd_pkg.sv
package thd_pkg;
  parameter int CH_W   = 3;
  parameter int TS_W   = 16;
  parameter int NCH    = 1 << CH_W;
  parameter int WORD_W = 1 + CH_W + TS_W;

  typedef struct packed {
    logic            lead;
    logic [CH_W-1:0] ch;
    logic [TS_W-1:0] ts;
  } hit_word_t;

  // Build a FIFO record; a forced close carries the saturated time.
  function automatic hit_word_t make_word(input logic lead,
                                          input logic [CH_W-1:0] ch,
                                          input logic [TS_W-1:0] ts,
                                          input logic forced);
    hit_word_t w;
    w.lead = lead;
    w.ch   = ch;
    w.ts   = forced ? {TS_W{1'b1}} : ts;
    return w;
  endfunction

  // Pulse duration in periods from a leading/trailing pair (modulo wrap).
  function automatic logic [TS_W-1:0] tot_periods(input logic [TS_W-1:0] t_lead,
                                                  input logic [TS_W-1:0] t_trail);
    return t_trail - t_lead;
  endfunction
endpackage

// File: rtl/thd_sync.sv
module thd_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/thd_scan.sv
module thd_scan import thd_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  output logic [CH_W-1:0] slot,
  output logic [TS_W-1:0] period_cnt,
  output logic            period_end
);
  localparam logic [CH_W-1:0] SLOT_LAST = CH_W'(NCH - 1);

  assign period_end = (slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= '0;
      period_cnt <= '0;
    end else begin
      slot <= slot + 1'b1;
      if (period_end) period_cnt <= period_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/thd_chan.sv
module thd_chan #(
  parameter int MAX_OPEN = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic visit,
  input  logic low_s,
  input  logic rd_s,
  output logic ev_lead,
  output logic ev_trail,
  output logic ev_force,
  output logic open_o
);
  localparam int AGE_W = $clog2(MAX_OPEN + 1);
  localparam logic [AGE_W-1:0] AGE_LIMIT = AGE_W'(MAX_OPEN - 1);

  logic             prev_rd;
  logic             open_q;
  logic [AGE_W-1:0] age_q;
  logic             rise, fall;

  always_comb begin
    rise     = rd_s & ~prev_rd;
    fall     = ~rd_s & prev_rd;
    ev_lead  = visit & ~open_q & rise & low_s;
    ev_trail = visit & open_q & fall;
    ev_force = visit & open_q & ~fall & (age_q == AGE_LIMIT);
  end

  assign open_o = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rd <= 1'b0;
      open_q  <= 1'b0;
      age_q   <= '0;
    end else if (visit) begin
      prev_rd <= rd_s;
      if (ev_lead) begin
        open_q <= 1'b1;
        age_q  <= '0;
      end else if (ev_trail || ev_force) begin
        open_q <= 1'b0;
      end else if (open_q) begin
        age_q <= age_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/thd_fifo.sv
module thd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         full,
  output logic         valid,
  output logic [W-1:0] head
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   count;
  logic             do_push, do_pop;

  assign full    = (count == (PTR_W+1)'(DEPTH));
  assign valid   = (count != '0);
  assign head    = mem[rd_ptr];
  assign do_push = push & ~full;
  assign do_pop  = pop & valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tot_hit_digitizer.sv
module tot_hit_digitizer import thd_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_OPEN   = 255,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    low_cmp,
  input  logic [NCH-1:0]    rd_cmp,
  input  logic              rd_en,
  output logic              fifo_valid,
  output logic [WORD_W-1:0] fifo_word,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_count
);
  logic [NCH-1:0]    low_s, rd_s;
  logic [CH_W-1:0]   slot;
  logic [TS_W-1:0]   period_cnt;
  logic              period_end;
  logic [NCH-1:0]    lead_v, trail_v, force_v, open_v;
  logic              ev_valid, ev_lead, ev_force;
  logic              ev_push, ev_drop;
  logic              fifo_full;
  hit_word_t         ev_word;

  thd_sync #(.W(2*NCH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({low_cmp, rd_cmp}),
    .d_sync  ({low_s, rd_s})
  );

  thd_scan u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot),
    .period_cnt (period_cnt),
    .period_end (period_end)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    thd_chan #(.MAX_OPEN(MAX_OPEN)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .visit    (slot == CH_W'(c)),
      .low_s    (low_s[c]),
      .rd_s     (rd_s[c]),
      .ev_lead  (lead_v[c]),
      .ev_trail (trail_v[c]),
      .ev_force (force_v[c]),
      .open_o   (open_v[c])
    );
  end

  // Only the visited channel can raise an event, so OR-reduction selects it.
  assign ev_lead  = |lead_v;
  assign ev_force = |force_v;
  assign ev_valid = ev_lead | ev_force | (|trail_v);
  assign ev_word  = make_word(ev_lead, slot, period_cnt, ev_force);
  assign ev_push  = ev_valid & ~fifo_full;
  assign ev_drop  = ev_valid & fifo_full;

  thd_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .wdata (ev_word),
    .pop   (rd_en),
    .full  (fifo_full),
    .valid (fifo_valid),
    .head  (fifo_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow   <= 1'b0;
      drop_count <= '0;
    end else if (ev_drop) begin
      overflow <= 1'b1;
      if (drop_count != {DROP_W{1'b1}}) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/thd_checker.sv
module thd_checker import thd_pkg::*; #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    low_s,
  input logic              ev_valid,
  input logic              ev_lead,
  input logic              ev_force,
  input logic [WORD_W-1:0] ev_word,
  input logic              ev_drop,
  input logic              fifo_full,
  input logic              fifo_valid,
  input logic [WORD_W-1:0] fifo_word,
  input logic              rd_en,
  input logic              overflow,
  input logic [DROP_W-1:0] drop_count
);
  p_lead_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_lead) |-> low_s[ev_word[TS_W +: CH_W]]);

  p_forced_saturated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_force |-> (ev_valid && !ev_word[WORD_W-1] && (ev_word[TS_W-1:0] == {TS_W{1'b1}})));

  p_drop_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> fifo_full);

  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_drop_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && (drop_count != {DROP_W{1'b1}})) |=> (drop_count == $past(drop_count) + 1'b1));

  p_head_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !rd_en) |=> (fifo_valid && $stable(fifo_word)));

  p_empty_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_valid && !ev_valid) |=> !fifo_valid);
endmodule

bind tot_hit_digitizer thd_checker #(.DROP_W(DROP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .low_s      (low_s),
  .ev_valid   (ev_valid),
  .ev_lead    (ev_lead),
  .ev_force   (ev_force),
  .ev_word    (ev_word),
  .ev_drop    (ev_drop),
  .fifo_full  (fifo_full),
  .fifo_valid (fifo_valid),
  .fifo_word  (fifo_word),
  .rd_en      (rd_en),
  .overflow   (overflow),
  .drop_count (drop_count)
);

// File: tb/tot_hit_digitizer_test.sv
`timescale 1ns/1ps
module tot_hit_digitizer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  low_cmp = '0;
  logic [7:0]  rd_cmp = '0;
  logic        rd_en = 1'b0;
  logic        fifo_valid;
  logic [19:0] fifo_word;
  logic        overflow;
  logic [7:0]  drop_count;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tot_hit_digitizer uut (
    .clk(clk), .rst_n(rst_n), .low_cmp(low_cmp), .rd_cmp(rd_cmp),
    .rd_en(rd_en), .fifo_valid(fifo_valid), .fifo_word(fifo_word),
    .overflow(overflow), .drop_count(drop_count)
  );

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_word(output logic [19:0] w, output bit ok);
    @(negedge clk);
    ok = fifo_valid;
    w  = fifo_word;
    if (ok) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  // Low comparator opens one period early; readout high for w periods.
  task automatic pulse(logic [7:0] m, int w);
    low_cmp |= m;  wait_cyc(8);
    rd_cmp  |= m;  wait_cyc(8 * w);
    rd_cmp  &= ~m; wait_cyc(8);
    low_cmp &= ~m; wait_cyc(24);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 fifo_valid", fifo_valid, 0);
    check("R1 overflow", overflow, 0);
    check("R1 drop_count", drop_count, 0);
  endtask

  task automatic t_single();
    logic [19:0] a, b; bit oka, okb; int p0;
    low_cmp[3] = 1'b1; wait_cyc(8);
    p0 = cyc / 8;
    rd_cmp[3] = 1'b1; wait_cyc(32);
    rd_cmp[3] = 1'b0; wait_cyc(8);
    low_cmp[3] = 1'b0; wait_cyc(24);
    pop_word(a, oka); pop_word(b, okb);
    check("R2 lead present", oka, 1);
    check("R2 lead type", a[19], 1);
    check("R2 lead channel", a[18:16], 3);
    check("R2 lead time in range", (a[15:0] >= p0 && a[15:0] <= p0 + 2), 1);
    check("R4 trail present", okb, 1);
    check("R4 trail type", b[19], 0);
    check("R4 trail channel", b[18:16], 3);
    check("R4 tot width 4", b[15:0] - a[15:0], 4);
    @(negedge clk);
    check("R8 empty after pair", fifo_valid, 0);
  endtask

  task automatic t_window();
    rd_cmp[5] = 1'b1; wait_cyc(24);
    check("R3 no lead outside window", fifo_valid, 0);
    low_cmp[5] = 1'b1; wait_cyc(24);
    check("R3 late window opens nothing", fifo_valid, 0);
    rd_cmp[5] = 1'b0; wait_cyc(24);
    check("R5 no trail without open lead", fifo_valid, 0);
    low_cmp[5] = 1'b0; wait_cyc(8);
  endtask

  task automatic t_widths();
    logic [19:0] a, b; bit oka, okb;
    pulse(8'h01, 1);
    pop_word(a, oka); pop_word(b, okb);
    check("R4 ch0 order lead", {oka, a[19], a[18:16]}, {1'b1, 1'b1, 3'd0});
    check("R4 ch0 tot width 1", b[15:0] - a[15:0], 1);
    pulse(8'h80, 9);
    pop_word(a, oka); pop_word(b, okb);
    check("R4 ch7 trail fields", {okb, b[19], b[18:16]}, {1'b1, 1'b0, 3'd7});
    check("R4 ch7 tot width 9", b[15:0] - a[15:0], 9);
  endtask

  task automatic t_all();
    logic [19:0] w; bit ok; int lead_ts[8]; logic [7:0] lm, tm; int n;
    lm = '0; tm = '0; n = 0;
    pulse(8'hFF, 2);
    for (int i = 0; i < 20; i++) begin
      pop_word(w, ok);
      if (!ok) break;
      n++;
      if (w[19]) begin
        lm[w[18:16]] = 1'b1;
        lead_ts[w[18:16]] = int'(w[15:0]);
      end else begin
        check("R8 trail after lead", lm[w[18:16]], 1);
        check("R4 all-channel tot width 2", (int'(w[15:0]) - lead_ts[w[18:16]]) & 16'hFFFF, 2);
        tm[w[18:16]] = 1'b1;
      end
    end
    check("R9 record count", n, 16);
    check("R9 lead per channel", lm, 8'hFF);
    check("R9 trail per channel", tm, 8'hFF);
  endtask

  task automatic t_timeout();
    logic [19:0] a, b; bit oka, okb;
    low_cmp[2] = 1'b1; wait_cyc(8);
    rd_cmp[2] = 1'b1; wait_cyc(24);
    pop_word(a, oka);
    check("R6 lead before timeout", {oka, a[19], a[18:16]}, {1'b1, 1'b1, 3'd2});
    wait_cyc(8 * 250);
    @(negedge clk);
    check("R6 not forced early", fifo_valid, 0);
    wait_cyc(8 * 8);
    pop_word(b, okb);
    check("R6 forced trail fields", {okb, b[19], b[18:16]}, {1'b1, 1'b0, 3'd2});
    check("R6 forced timestamp", b[15:0], 16'hFFFF);
    rd_cmp[2] = 1'b0; wait_cyc(24);
    check("R5 fall after force ignored", fifo_valid, 0);
    low_cmp[2] = 1'b0; wait_cyc(8);
  endtask

  task automatic t_overflow();
    logic [19:0] w; bit ok; int n;
    n = 0;
    pulse(8'hFF, 1);
    pulse(8'hFF, 1);
    check("R7 overflow set", overflow, 1);
    check("R7 drop count", drop_count, 16);
    for (int i = 0; i < 20; i++) begin
      pop_word(w, ok);
      if (!ok) break;
      n++;
    end
    check("R7 stored up to depth", n, 16);
    check("R7 overflow sticky", overflow, 1);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_window();
    t_widths();
    t_all();
    t_timeout();
    t_overflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule